// File: doc/BRIEF.md
# Parallel Flash Programming Command Controller

This block is the command front end that an external programmer uses to erase, program, lock and read back the on-chip flash of a small microcontroller in parallel mode. The host presents a 4-bit mode code, an address and a data byte on dedicated pins. It then pulls an active-low strobe from high to low to start a write-type operation. The controller synchronises the strobe, decodes the mode and checks the block's lock field. It then runs the operation for an internally timed number of cycles. A ready output is low while the operation runs.

Write-type commands are refused until the controller has been armed. Arming happens when the host presents the signature-read mode code. A reset, which stands in for power-off, disarms the controller again. The flash array is a behavioural byte model with 2**ARRAY_AW locations split into two equal blocks. The top address bit selects the block, and each block has a 3-bit lock field. Programming can only clear bits. Erase returns every byte to 0xFF. Verify and signature reads are registered and appear on the data output one clock later.

Top module: `fpgm_ctrl`

## Requirements
- R1: After reset ready_o is 1, data_o is 0x00, the controller is unarmed, every array byte is 0xFF and both lock fields are 0.
- R2: While unarmed, a strobe falling edge with any write-type code (erase 4'h1, program 4'hE, lock 4'h7) does nothing: ready_o stays 1 and the array and locks are unchanged.
- R3: Presenting mode 4'h3 (signature read) arms the controller until the next reset, and one clock later data_o shows 0xD5 when addr_i[0] is 0 and 0x7B when addr_i[0] is 1.
- R4: An accepted write command drives ready_o low for exactly PROG_LAT cycles (program, lock) or ERASE_LAT cycles (erase), starting within three clocks of the strobe falling edge; the array change is visible once ready_o is high again.
- R5: Chip erase (mode 4'h1) sets every byte to 0xFF and clears both lock fields, whatever the lock bits hold.
- R6: Program (mode 4'hE) replaces the byte at addr_i with the bitwise AND of its old value and data_i, so a byte that is not erased can only lose 1 bits.
- R7: Program is refused (ready_o stays 1, array unchanged) when bit 1 or bit 2 of the addressed block's lock field is set; bit 0 alone does not block it.
- R8: Verify (mode 4'hC) needs no arming; one clock later data_o holds the addressed byte, or 0xFF if any bit of that block's lock field is set.
- R9: Lock (mode 4'h7) ORs data_i[2:0] into the lock field of the block selected by addr_i[ARRAY_AW-1] (0 = lower half, 1 = upper half); lock bits are only cleared by erase or reset.
- R10: A strobe falling edge that arrives while ready_o is low is ignored: no second operation runs and its address and data are not used.
- R11: Any other mode code drives data_o to 0x00 and a strobe falling edge with it starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| prog_n_i | input | 1 | Asynchronous active-low operation strobe |
| mode_i | input | 4 | Mode code |
| addr_i | input | ARRAY_AW | Byte address; the top bit selects the block |
| data_i | input | 8 | Program data or lock bits |
| data_o | output | 8 | Registered verify or signature data |
| ready_o | output | 1 | 1 = idle, 0 = operation running |

## Verification
The bench programs every location of a 64-byte array with a computed pattern and then reads all of it back. It also reprograms a byte that is not erased, where a design that overwrote instead of ANDing would show the new data. It strobes write commands before arming and after a reset, so a design that armed at power-up or kept the armed state would show ready pulses and changed bytes. It sets each lock bit on one block, so a design with the program and verify rules swapped would return real data from a locked block or refuse a program under lock bit 0 alone. A second strobe during a running operation tests that a design which restarted would stretch the busy time or write the second address.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

    localparam logic [3:0] ERASE_CODE = 4'h1;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SIG,
        OP_ERASE,
        OP_PROG,
        OP_VERIFY,
        OP_LOCK
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] data;
    } job_t;

    typedef logic [1:0][2:0] lock_set_t;

    function automatic op_e decode_mode(
        input logic [3:0] mode,
        input logic [3:0] sig_code,
        input logic [3:0] prog_code,
        input logic [3:0] verify_code,
        input logic [3:0] lock_code
    );
        op_e r;
        if (mode == ERASE_CODE)       r = OP_ERASE;
        else if (mode == sig_code)    r = OP_SIG;
        else if (mode == prog_code)   r = OP_PROG;
        else if (mode == verify_code) r = OP_VERIFY;
        else if (mode == lock_code)   r = OP_LOCK;
        else                          r = OP_NONE;
        return r;
    endfunction

    function automatic logic is_write(input op_e op);
        return (op == OP_ERASE) || (op == OP_PROG) || (op == OP_LOCK);
    endfunction

    function automatic logic prog_denied(input logic [2:0] lk);
        return lk[1] | lk[2];
    endfunction

    function automatic logic read_denied(input logic [2:0] lk);
        return |lk;
    endfunction

endpackage

// File: rtl/fpgm_strobe_sync.sv
module fpgm_strobe_sync (
    input  logic clk,
    input  logic rst,
    input  logic prog_n_i,
    output logic fall_o
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= prog_n_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fall_o = prev_q & ~s2_q;

    // R4: an edge pulse lasts a single cycle
    p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/fpgm_cmd_gate.sv
module fpgm_cmd_gate
    import fpgm_pkg::*;
#(
    parameter logic [3:0] SIG_CODE    = 4'h3,
    parameter logic [3:0] PROG_CODE   = 4'hE,
    parameter logic [3:0] VERIFY_CODE = 4'hC,
    parameter logic [3:0] LOCK_CODE   = 4'h7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode_i,
    input  logic       fall_i,
    input  logic       busy_i,
    input  logic       blk_i,
    input  lock_set_t  lk_i,
    output op_e        op_o,
    output logic       start_o,
    output logic       armed_o
);
    logic armed_q;
    logic allowed;

    assign op_o = decode_mode(mode_i, SIG_CODE, PROG_CODE, VERIFY_CODE, LOCK_CODE);

    always_ff @(posedge clk) begin
        if (rst)               armed_q <= 1'b0;
        else if (op_o == OP_SIG) armed_q <= 1'b1;
    end

    always_comb begin
        allowed = is_write(op_o);
        if (op_o == OP_PROG && prog_denied(lk_i[blk_i]))
            allowed = 1'b0;
    end

    assign start_o = fall_i & ~busy_i & armed_q & allowed;
    assign armed_o = armed_q;

    // R3: once armed, stays armed until reset
    p_armed_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> armed_q);
endmodule

// File: rtl/fpgm_timer.sv
module fpgm_timer
    import fpgm_pkg::*;
#(
    parameter int PROG_LAT  = 16,
    parameter int ERASE_LAT = 64,
    parameter int AW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  op_e           op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          busy_o,
    output logic          commit_o,
    output job_t          job_o,
    output logic [AW-1:0] job_addr_o
);
    localparam int MAXLAT = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT;
    localparam int CW     = $clog2(MAXLAT + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    job_t          job_q;
    logic [AW-1:0] addr_q;

    assign commit_o = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            job_q  <= '{op: OP_NONE, data: 8'h00};
            addr_q <= '0;
        end else if (start_i && !busy_q) begin
            busy_q     <= 1'b1;
            cnt_q      <= (op_i == OP_ERASE) ? CW'(ERASE_LAT - 1) : CW'(PROG_LAT - 1);
            job_q.op   <= op_i;
            job_q.data <= data_i;
            addr_q     <= addr_i;
        end else if (commit_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o     = busy_q;
    assign job_o      = job_q;
    assign job_addr_o = addr_q;

    // R10: a new operation starts only from idle
    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_q);
    // R4: busy holds until the counter runs out
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q);
    // R4: commit ends the operation
    p_commit_ends_r4: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !busy_q);
endmodule

// File: rtl/fpgm_array.sv
module fpgm_array
    import fpgm_pkg::*;
#(
    parameter int         AW     = 10,
    parameter logic [7:0] SIG_LO = 8'hD5,
    parameter logic [7:0] SIG_HI = 8'h7B
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_i,
    input  job_t          job_i,
    input  logic [AW-1:0] job_addr_i,
    input  op_e           rd_op_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    data_o,
    output lock_set_t     lk_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    lock_set_t  lk_q;
    logic [7:0] rd_q;
    logic       wblk;
    logic       rblk;

    assign wblk = job_addr_i[AW-1];
    assign rblk = rd_addr_i[AW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            lk_q <= '0;
        end else if (commit_i) begin
            case (job_i.op)
                OP_ERASE: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                    lk_q <= '0;
                end
                OP_PROG:  mem[job_addr_i] <= mem[job_addr_i] & job_i.data;
                OP_LOCK:  lk_q[wblk] <= lk_q[wblk] | job_i.data[2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 8'h00;
        end else begin
            case (rd_op_i)
                OP_VERIFY: rd_q <= read_denied(lk_q[rblk]) ? 8'hFF : mem[rd_addr_i];
                OP_SIG:    rd_q <= rd_addr_i[0] ? SIG_HI : SIG_LO;
                default:   rd_q <= 8'h00;
            endcase
        end
    end

    assign data_o = rd_q;
    assign lk_o   = lk_q;

    // R7: a program never commits into a block locked by bit 1 or bit 2
    p_prog_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
        (commit_i && job_i.op == OP_PROG) |-> !prog_denied(lk_q[wblk]));
    // R5: erase leaves both lock fields clear
    p_erase_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
        (commit_i && job_i.op == OP_ERASE) |=> (lk_q == '0));
    // R9: lock bits never clear without an erase
    p_lock_monotone_r9: assert property (@(posedge clk) disable iff (rst)
        !(commit_i && job_i.op == OP_ERASE) |=> ((lk_q & $past(lk_q)) == $past(lk_q)));
endmodule

// File: rtl/fpgm_ctrl.sv
module fpgm_ctrl
    import fpgm_pkg::*;
#(
    parameter int         ARRAY_AW    = 10,
    parameter int         PROG_LAT    = 16,
    parameter int         ERASE_LAT   = 64,
    parameter logic [3:0] SIG_CODE    = 4'h3,
    parameter logic [3:0] PROG_CODE   = 4'hE,
    parameter logic [3:0] VERIFY_CODE = 4'hC,
    parameter logic [3:0] LOCK_CODE   = 4'h7,
    parameter logic [7:0] SIG_LO      = 8'hD5,
    parameter logic [7:0] SIG_HI      = 8'h7B
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prog_n_i,
    input  logic [3:0]          mode_i,
    input  logic [ARRAY_AW-1:0] addr_i,
    input  logic [7:0]          data_i,
    output logic [7:0]          data_o,
    output logic                ready_o
);
    logic                fall;
    logic                busy;
    logic                start;
    logic                armed;
    logic                commit;
    op_e                 op;
    job_t                job;
    logic [ARRAY_AW-1:0] job_addr;
    lock_set_t           lk;

    fpgm_strobe_sync u_sync (
        .clk(clk), .rst(rst), .prog_n_i(prog_n_i), .fall_o(fall)
    );

    fpgm_cmd_gate #(
        .SIG_CODE(SIG_CODE), .PROG_CODE(PROG_CODE),
        .VERIFY_CODE(VERIFY_CODE), .LOCK_CODE(LOCK_CODE)
    ) u_gate (
        .clk(clk), .rst(rst), .mode_i(mode_i), .fall_i(fall), .busy_i(busy),
        .blk_i(addr_i[ARRAY_AW-1]), .lk_i(lk), .op_o(op), .start_o(start),
        .armed_o(armed)
    );

    fpgm_timer #(
        .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT), .AW(ARRAY_AW)
    ) u_timer (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .addr_i(addr_i),
        .data_i(data_i), .busy_o(busy), .commit_o(commit), .job_o(job),
        .job_addr_o(job_addr)
    );

    fpgm_array #(
        .AW(ARRAY_AW), .SIG_LO(SIG_LO), .SIG_HI(SIG_HI)
    ) u_array (
        .clk(clk), .rst(rst), .commit_i(commit), .job_i(job),
        .job_addr_i(job_addr), .rd_op_i(op), .rd_addr_i(addr_i),
        .data_o(data_o), .lk_o(lk)
    );

    assign ready_o = ~busy;

    // R2: ready only drops for an armed controller
    p_ready_armed_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(armed));
    // R4: ready only drops right after a strobe falling edge
    p_ready_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(fall));
endmodule

// File: tb/fpgm_ctrl_tb.sv
module fpgm_ctrl_tb;
    localparam int CLK_NS = 10;
    localparam int AW     = 6;
    localparam int DEPTH  = 1 << AW;
    localparam int PLAT   = 8;
    localparam int ELAT   = 12;
    localparam int WIN    = ELAT + 8;

    localparam logic [3:0] M_ERASE = 4'h1, M_SIG = 4'h3, M_PROG = 4'hE;
    localparam logic [3:0] M_VER = 4'hC, M_LOCK = 4'h7, M_IDLE = 4'hF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_n = 1'b1;
    logic [3:0]    mode = M_IDLE;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic [7:0]    dout;
    logic          ready;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_mem [DEPTH];
    logic [2:0] exp_lk [2];

    fpgm_ctrl #(.ARRAY_AW(AW), .PROG_LAT(PLAT), .ERASE_LAT(ELAT)) u_dut (
        .clk(clk), .rst(rst), .prog_n_i(prog_n), .mode_i(mode),
        .addr_i(addr), .data_i(din), .data_o(dout), .ready_o(ready)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        exp_lk[0] = 3'b000;
        exp_lk[1] = 3'b000;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; prog_n = 1'b1; mode = M_IDLE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // strobe a command and count the cycles ready is low
    task automatic strobe(input logic [3:0] m, input logic [AW-1:0] a,
                          input logic [7:0] d, output int lows);
        @(negedge clk); mode = m; addr = a; din = d; prog_n = 1'b0;
        lows = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (!ready) lows++;
        end
        prog_n = 1'b1; mode = M_IDLE;
        repeat (3) @(negedge clk);
    endtask

    task automatic read(input logic [3:0] m, input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk); mode = m; addr = a;
        repeat (2) @(negedge clk);
        v = dout;
        mode = M_IDLE;
    endtask

    function automatic logic [7:0] exp_ver(input int a);
        return (exp_lk[a >> (AW-1)] != 3'b000) ? 8'hFF : exp_mem[a];
    endfunction

    task automatic verify_all(input string req);
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) begin
            read(M_VER, AW'(a), v);
            check(req, v, exp_ver(a));
        end
    endtask

    initial begin
        int lows;
        logic [7:0] v;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", ready, 1);
        check("R1 data", dout, 0);
        verify_all("R1/R8 erased array");

        // R2 unarmed writes ignored
        strobe(M_PROG, 6'd5, 8'h12, lows);
        check("R2 prog busy", lows, 0);
        strobe(M_LOCK, 6'd40, 8'h07, lows);
        check("R2 lock busy", lows, 0);
        strobe(M_ERASE, 6'd0, 8'h00, lows);
        check("R2 erase busy", lows, 0);
        verify_all("R2 array unchanged");

        // R3 signature read arms
        read(M_SIG, 6'd0, v); check("R3 sig lo", v, 8'hD5);
        read(M_SIG, 6'd1, v); check("R3 sig hi", v, 8'h7B);

        // R11 unknown code
        read(4'h5, 6'd3, v); check("R11 data", v, 0);
        strobe(4'h5, 6'd3, 8'h00, lows); check("R11 busy", lows, 0);

        // R4/R6 program sweep
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 11) & 8'hFF);
            strobe(M_PROG, AW'(a), d, lows);
            check("R4 prog busy", lows, PLAT);
            exp_mem[a] = exp_mem[a] & d;
        end
        verify_all("R6 program sweep");

        // R6 reprogram a non-erased byte
        strobe(M_PROG, 6'd3, 8'hF0, lows);
        exp_mem[3] = exp_mem[3] & 8'hF0;
        read(M_VER, 6'd3, v); check("R6 and", v, exp_mem[3]);

        // R10 strobe during busy
        @(negedge clk); mode = M_PROG; addr = 6'd10; din = 8'h0F; prog_n = 1'b0;
        lows = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (!ready) lows++;
            if (i == 2) prog_n = 1'b1;
            if (i == 4) begin addr = 6'd20; din = 8'h00; prog_n = 1'b0; end
        end
        prog_n = 1'b1; mode = M_IDLE;
        repeat (3) @(negedge clk);
        exp_mem[10] = exp_mem[10] & 8'h0F;
        check("R10 busy len", lows, PLAT);
        read(M_VER, 6'd20, v); check("R10 second ignored", v, exp_mem[20]);
        read(M_VER, 6'd10, v); check("R10 first done", v, exp_mem[10]);

        // R9/R8 lock bit 0 on block 1
        strobe(M_LOCK, 6'd32, 8'h01, lows);
        check("R9 lock busy", lows, PLAT);
        exp_lk[1] = 3'b001;
        read(M_VER, 6'd33, v); check("R8 locked reads FF", v, 8'hFF);
        read(M_VER, 6'd2, v);  check("R8 other block", v, exp_mem[2]);
        // R7 lock bit 0 alone allows program
        strobe(M_PROG, 6'd33, 8'h00, lows);
        check("R7 lock0 allows", lows, PLAT);
        exp_mem[33] = 8'h00;
        // R7 lock bit 1 on block 0 refuses
        strobe(M_LOCK, 6'd1, 8'h02, lows);
        exp_lk[0] = 3'b010;
        strobe(M_PROG, 6'd4, 8'h00, lows);
        check("R7 lock1 refuses", lows, 0);
        read(M_VER, 6'd4, v); check("R8 block0 locked", v, 8'hFF);

        // R5 erase ignores locks
        strobe(M_ERASE, 6'd0, 8'h00, lows);
        check("R5 erase busy", lows, ELAT);
        model_reset();
        verify_all("R5 erased");

        // R7 lock bit 2 refuses
        strobe(M_LOCK, 6'd50, 8'h04, lows);
        exp_lk[1] = 3'b100;
        strobe(M_PROG, 6'd50, 8'h00, lows);
        check("R7 lock2 refuses", lows, 0);
        strobe(M_PROG, 6'd7, 8'h5A, lows);
        check("R7 other block ok", lows, PLAT);
        exp_mem[7] = 8'h5A;
        read(M_VER, 6'd7, v); check("R6 block0 data", v, 8'h5A);

        // R1/R2 reset disarms
        do_reset();
        check("R1 ready after reset", ready, 1);
        strobe(M_PROG, 6'd7, 8'h00, lows);
        check("R2 disarmed after reset", lows, 0);
        read(M_VER, 6'd7, v); check("R1 array after reset", v, 8'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule